// File: doc/BRIEF.md
# Dual-Strobe Presettable Up/Down Counter

This block is a binary counter with no direction bit. It counts up on a rising edge of one strobe and down on a rising edge of a second strobe. While neither strobe is active, both strobes idle high. A level-sensitive clear and an active-low parallel load override the counting. Two active-low terminal outputs copy the low phase of the active strobe whenever the counter sits at its end value for that direction. Because of this, a second stage can take those outputs as its own strobes.

The whole design runs on one system clock. The two external strobes pass through a two-flop synchronizer and are edge-detected in that clock domain. The top level chains `STAGES` counters of `STAGE_W` bits. The first stage synchronizes the external strobes. Each later stage takes the carry and borrow of the stage below it as its up and down strobes. The chain therefore behaves as a single `STAGES*STAGE_W`-bit counter.

Top module: `updn_cascade`

## Requirements
- R1: A rising edge of the up strobe, while the down strobe is high and has not risen in the same cycle, adds one to the count. The count wraps from all-ones to zero.
- R2: A rising edge of the down strobe, while the up strobe is high and has not risen in the same cycle, subtracts one from the count. The count wraps from zero to all-ones.
- R3: While `clr` is high, the count becomes zero on each clock edge. Clear takes priority over load and over both strobes, and strobe edges seen during clear are discarded.
- R4: While `load_n` is low and `clr` is low, the count takes `load_val` on each clock edge and follows changes to it. Strobe edges seen during load are discarded.
- R5: `carry_n` is low exactly when three things hold: the count is all-ones, the synchronized up strobe is low, and the synchronized down strobe is high. Otherwise it is high.
- R6: `borrow_n` is low exactly when three things hold: the count is zero, the synchronized down strobe is low, and the synchronized up strobe is high. Otherwise it is high.
- R7: If a strobe stays low through a clear or load and after it, its first rising edge after the release is counted.
- R8: In each of the following cases the count holds, and `illegal` is high for exactly one cycle, the cycle in which the count would have changed:
  - both strobes rise together;
  - the up strobe rises while the down strobe is low;
  - the down strobe rises while the up strobe is low.
  No flag is raised while clear or load is active.
- R9: A strobe rise applied between clock edges changes the count, and raises `illegal` where R8 applies, after the third following rising clock edge. A strobe level change reaches `carry_n` and `borrow_n` after the second rising edge.
- R10: The stages form one binary counter of `STAGES*STAGE_W` bits. The up and down sequences cover every value in order, and the carry and borrow pass between stages with no extra cycle.
- R11: While `rst_n` is low at a clock edge, the following reset state applies:
  - the count is zero;
  - `illegal` is low;
  - `carry_n` and `borrow_n` are high;
  - both synchronized strobes are treated as high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Clear to zero, active high, sampled on the clock |
| load_n | input | 1 | Parallel load, active low, sampled on the clock |
| load_val | input | STAGES*STAGE_W | Value loaded while `load_n` is low |
| up_strb | input | 1 | Count-up strobe, asynchronous, idles high |
| dn_strb | input | 1 | Count-down strobe, asynchronous, idles high |
| count | output | STAGES*STAGE_W | Current count |
| carry_n | output | 1 | Terminal count up, active low |
| borrow_n | output | 1 | Terminal count down, active low |
| illegal | output | 1 | One-cycle pulse on an ignored conflicting strobe edge |

## Verification
A raw strobe change is applied at a falling clock edge. Its effect on the count and on `illegal` becomes visible after the third rising edge. Its effect on `carry_n` and `borrow_n` becomes visible after the second rising edge. Clear and load take effect at the very next rising edge.

The bench carries its own cycle model: an integer total, shift variables for the strobe pipeline, and the edge rules of the requirements. The model advances at each rising edge, and every output is compared with it at each falling edge, so each result is checked in the cycle it is due. Dedicated checks count edges explicitly to confirm the three-edge latency. Further dedicated checks confirm that a conflicting strobe edge leaves the count unchanged and raises `illegal` for exactly one cycle.

// File: rtl/updn_pkg.sv
// Shared types for the dual-strobe counter.
package updn_pkg;

    // One sample of both strobes; both idle high.
    typedef struct packed {
        logic up;
        logic dn;
    } strobe_pair_t;

    localparam strobe_pair_t STROBE_IDLE = '{up: 1'b1, dn: 1'b1};

endpackage

// File: rtl/strobe_edge.sv
// Strobe front end: optional two-flop synchronizer, then rising-edge detection.
// Assumes: strobes idle high. While hold is high, the edge memory is forced
// high, so no edge is reported for a rise that happened under hold. A strobe
// that is still low after hold ends gives one normal sample of 0, which keeps
// its next rise valid.
module strobe_edge
    import updn_pkg::*;
#(
    parameter bit SYNC_EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  strobe_pair_t raw,
    output strobe_pair_t lvl,
    output strobe_pair_t rise
);

    strobe_pair_t prev_q;

    generate
        if (SYNC_EN) begin : g_sync
            strobe_pair_t meta_q;
            strobe_pair_t sync_q;

            // Two-stage synchronizer for strobes from outside the clock domain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= STROBE_IDLE;
                    sync_q <= STROBE_IDLE;
                end else begin
                    meta_q <= raw;
                    sync_q <= meta_q;
                end
            end
            assign lvl = sync_q;
        end else begin : g_direct
            // Strobes already in the clock domain (from a lower stage).
            assign lvl = raw;
        end
    endgenerate

    // Edge memory: last level seen outside hold, forced idle under hold.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            prev_q <= STROBE_IDLE;
        end else begin
            prev_q <= lvl;
        end
    end

    // Rising edge: level now high, previous sample low.
    always_comb begin
        rise.up = lvl.up & ~prev_q.up;
        rise.dn = lvl.dn & ~prev_q.dn;
    end

endmodule

// File: rtl/updn_stage.sv
// One counter stage of CNT_W bits, counting on rising edges of two strobes.
// Assumes: clr and load_n are synchronous to clk. The terminal outputs are
// decoded from the registered count and the strobe levels in the clock domain.
module updn_stage
    import updn_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter bit SYNC_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load_n,
    input  logic [CNT_W-1:0] data,
    input  logic             up_in,
    input  logic             dn_in,
    output logic [CNT_W-1:0] count,
    output logic             carry_n,
    output logic             borrow_n,
    output logic             illegal
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    strobe_pair_t     raw_s, lvl_s, rise_s;
    logic             override;
    logic             conflict;
    logic [CNT_W-1:0] count_q;
    logic             illegal_q;

    assign raw_s.up = up_in;
    assign raw_s.dn = dn_in;
    assign override = clr | ~load_n;

    strobe_edge #(.SYNC_EN(SYNC_EN)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .hold (override),
        .raw  (raw_s),
        .lvl  (lvl_s),
        .rise (rise_s)
    );

    // Conflict: simultaneous rises, or a rise while the other strobe is low.
    assign conflict = (rise_s.up & rise_s.dn)
                    | (rise_s.up & ~lvl_s.dn)
                    | (rise_s.dn & ~lvl_s.up);

    // Count register: clear, then load, then one step per legal edge.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count_q <= '0;
        end else if (!load_n) begin
            count_q <= data;
        end else if (!conflict && rise_s.up) begin
            count_q <= count_q + CNT_ONE;
        end else if (!conflict && rise_s.dn) begin
            count_q <= count_q - CNT_ONE;
        end
    end

    // Conflict flag: one-cycle pulse, suppressed under override.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            illegal_q <= 1'b0;
        end else begin
            illegal_q <= conflict & ~override;
        end
    end

    // Terminal outputs copy the low phase of the active strobe at the ends.
    assign carry_n  = ~((count_q == CNT_MAX) & ~lvl_s.up & lvl_s.dn);
    assign borrow_n = ~((count_q == '0)      & ~lvl_s.dn & lvl_s.up);
    assign count    = count_q;
    assign illegal  = illegal_q;

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count_q == '0)); // R3

    AST_LOAD_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !load_n) |=> (count_q == $past(data))); // R4

    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!override && rise_s.up && !rise_s.dn && lvl_s.dn)
        |=> (count_q == $past(count_q) + CNT_ONE)); // R1

    AST_DN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!override && rise_s.dn && !rise_s.up && lvl_s.up)
        |=> (count_q == $past(count_q) - CNT_ONE)); // R2

    AST_CONFLICT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_q |-> $stable(count_q)); // R8

    AST_CARRY_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_n |-> (count_q == CNT_MAX)); // R5

    AST_BORROW_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !borrow_n |-> (count_q == '0)); // R6

endmodule

// File: rtl/updn_cascade.sv
// Chain of STAGES counter stages forming one STAGES*STAGE_W-bit counter.
// Stage 0 synchronizes the external strobes. Each later stage takes the
// carry and borrow of the stage below as its up and down strobes. Clear and
// load reach all stages in the same cycle.
module updn_cascade #(
    parameter int STAGE_W = 4,
    parameter int STAGES  = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        load_n,
    input  logic [STAGES*STAGE_W-1:0]   load_val,
    input  logic                        up_strb,
    input  logic                        dn_strb,
    output logic [STAGES*STAGE_W-1:0]   count,
    output logic                        carry_n,
    output logic                        borrow_n,
    output logic                        illegal
);

    localparam int TOTAL_W = STAGES * STAGE_W;

    logic [STAGES:0]   up_chain;
    logic [STAGES:0]   dn_chain;
    logic [STAGES-1:0] ill_vec;

    assign up_chain[0] = up_strb;
    assign dn_chain[0] = dn_strb;

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            updn_stage #(
                .CNT_W  (STAGE_W),
                .SYNC_EN(k == 0)
            ) u_stage (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr     (clr),
                .load_n  (load_n),
                .data    (load_val[k*STAGE_W +: STAGE_W]),
                .up_in   (up_chain[k]),
                .dn_in   (dn_chain[k]),
                .count   (count[k*STAGE_W +: STAGE_W]),
                .carry_n (up_chain[k+1]),
                .borrow_n(dn_chain[k+1]),
                .illegal (ill_vec[k])
            );
        end
    endgenerate

    assign carry_n  = up_chain[STAGES];
    assign borrow_n = dn_chain[STAGES];
    assign illegal  = |ill_vec;

    AST_CHAIN_CARRY_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_n |-> (count == {TOTAL_W{1'b1}})); // R10

    AST_CHAIN_BORROW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !borrow_n |-> (count == '0)); // R10

    AST_TERM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(carry_n == 1'b0 && borrow_n == 1'b0)); // R5 R6

endmodule

// File: tb/sim_updn_cascade.sv
// Bench for updn_cascade: a behavioural cycle model advanced on each rising
// edge and compared with the outputs on each falling edge.
module sim_updn_cascade;

    localparam int  STAGE_W = 4;
    localparam int  STAGES  = 2;
    localparam int  TW      = STAGE_W * STAGES;
    localparam int  MODV    = 1 << TW;
    localparam time TCLK    = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          load_n = 1'b1;
    logic [TW-1:0] load_val = '0;
    logic          up_strb = 1'b1;
    logic          dn_strb = 1'b1;
    logic [TW-1:0] count;
    logic          carry_n, borrow_n, illegal;

    int    n_checks = 0;
    int    n_errors = 0;
    string tag = "R11";

    updn_cascade #(.STAGE_W(STAGE_W), .STAGES(STAGES)) u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n),
        .load_val(load_val), .up_strb(up_strb), .dn_strb(dn_strb),
        .count(count), .carry_n(carry_n), .borrow_n(borrow_n),
        .illegal(illegal)
    );

    always #(TCLK/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference model state: strobe pipeline, edge memory, total, flag.
    int m_tot = 0;
    bit m_s1u = 1, m_s2u = 1, m_pu = 1;
    bit m_s1d = 1, m_s2d = 1, m_pd = 1;
    bit m_ill = 0;

    // Model step per rising edge, following the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_tot = 0; m_ill = 0;
            m_s1u = 1; m_s2u = 1; m_pu = 1;
            m_s1d = 1; m_s2d = 1; m_pd = 1;
        end else begin
            bit ru, rd, bad, ovr;
            ru  = m_s2u && !m_pu;
            rd  = m_s2d && !m_pd;
            bad = (ru && rd) || (ru && !m_s2d) || (rd && !m_s2u);
            ovr = clr || !load_n;
            if (clr)               m_tot = 0;
            else if (!load_n)      m_tot = int'(load_val);
            else if (!bad && ru)   m_tot = (m_tot + 1) % MODV;
            else if (!bad && rd)   m_tot = (m_tot + MODV - 1) % MODV;
            m_ill = !ovr && bad;
            if (ovr) begin m_pu = 1; m_pd = 1; end
            else     begin m_pu = m_s2u; m_pd = m_s2d; end
            m_s2u = m_s1u; m_s1u = up_strb;
            m_s2d = m_s1d; m_s1d = dn_strb;
        end
    end

    // Per-cycle comparison on the falling edge.
    always @(negedge clk) begin
        bit ec, eb;
        ec = !((m_tot == MODV - 1) && !m_s2u && m_s2d);
        eb = !((m_tot == 0) && !m_s2d && m_s2u);
        chk(int'(count) == m_tot, tag, "count", int'(count), m_tot);
        chk(carry_n === ec, tag, "carry_n (R5)", int'(carry_n), int'(ec));
        chk(borrow_n === eb, tag, "borrow_n (R6)", int'(borrow_n), int'(eb));
        chk(illegal === m_ill, tag, "illegal (R8)", int'(illegal), int'(m_ill));
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_up();
        up_strb = 1'b0; cyc(3); up_strb = 1'b1; cyc(3);
    endtask

    task automatic pulse_dn();
        dn_strb = 1'b0; cyc(3); dn_strb = 1'b1; cyc(3);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        int c0, hits;
        cyc(3);
        tag = "R11";
        chk(count == '0 && carry_n && borrow_n && !illegal, "R11",
            "reset state", int'(count), 0);
        rst_n = 1'b1;
        cyc(3);

        // R9: count changes after the third rising edge.
        tag = "R9";
        up_strb = 1'b0; cyc(4);
        up_strb = 1'b1; c0 = int'(count);
        cyc(1); chk(int'(count) == c0, "R9", "after edge 1", int'(count), c0);
        cyc(1); chk(int'(count) == c0, "R9", "after edge 2", int'(count), c0);
        cyc(1); chk(int'(count) == c0 + 1, "R9", "after edge 3", int'(count), c0 + 1);
        cyc(3);

        // R1 / R10: full upward sequence with wrap, carry across stages.
        tag = "R1";
        for (int i = 0; i < MODV; i++) pulse_up();
        chk(int'(count) == 1, "R1", "up wrap back to 1", int'(count), 1);
        tag = "R10";
        load_n = 1'b0; load_val = 8'h0F; cyc(2); load_n = 1'b1; cyc(2);
        pulse_up();
        chk(count == 8'h10, "R10", "carry into upper stage", int'(count), 16);

        // R2 / R10: full downward sequence with wrap.
        tag = "R2";
        clr = 1'b1; cyc(1); clr = 1'b0; cyc(2);
        for (int i = 0; i < MODV + 3; i++) pulse_dn();
        chk(int'(count) == MODV - 3, "R2", "down wrap", int'(count), MODV - 3);
        tag = "R10";
        load_n = 1'b0; load_val = 8'h30; cyc(2); load_n = 1'b1; cyc(2);
        pulse_dn();
        chk(count == 8'h2F, "R10", "borrow from upper stage", int'(count), 47);

        // R5 / R6: terminal outputs at the ends.
        tag = "R5";
        load_n = 1'b0; load_val = 8'hFF; cyc(2); load_n = 1'b1; cyc(2);
        up_strb = 1'b0; cyc(3);
        chk(carry_n == 1'b0, "R5", "carry low at max", int'(carry_n), 0);
        up_strb = 1'b1; cyc(3);
        chk(count == 8'h00 && carry_n, "R5", "wrap and carry release", int'(count), 0);
        tag = "R6";
        dn_strb = 1'b0; cyc(3);
        chk(borrow_n == 1'b0, "R6", "borrow low at zero", int'(borrow_n), 0);
        dn_strb = 1'b1; cyc(3);

        // R4: load follows data and ignores strobes.
        tag = "R4";
        load_n = 1'b0; load_val = 8'h5A; cyc(2);
        chk(count == 8'h5A, "R4", "load value", int'(count), 90);
        load_val = 8'hA5; up_strb = 1'b0; cyc(3); up_strb = 1'b1; cyc(3);
        chk(count == 8'hA5, "R4", "load follows, strobe ignored", int'(count), 165);
        load_n = 1'b1; cyc(4);
        chk(count == 8'hA5, "R4", "no edge after load release", int'(count), 165);

        // R3: clear beats load and strobes.
        tag = "R3";
        load_n = 1'b0; clr = 1'b1; cyc(2);
        chk(count == '0, "R3", "clear over load", int'(count), 0);
        load_n = 1'b1; clr = 1'b0; cyc(3);

        // R7: strobe held low through clear, first rise afterwards counts.
        tag = "R7";
        up_strb = 1'b0; cyc(3);
        clr = 1'b1; cyc(2); clr = 1'b0; cyc(2);
        up_strb = 1'b1; cyc(4);
        chk(int'(count) == 1, "R7", "rise after clear counted", int'(count), 1);

        // R8: simultaneous rises and rise with other strobe low.
        tag = "R8";
        up_strb = 1'b0; dn_strb = 1'b0; cyc(4);
        up_strb = 1'b1; dn_strb = 1'b1; hits = 0;
        for (int i = 0; i < 6; i++) begin cyc(1); if (illegal) hits++; end
        chk(hits == 1, "R8", "one pulse on dual rise", hits, 1);
        chk(int'(count) == 1, "R8", "count held on dual rise", int'(count), 1);
        dn_strb = 1'b0; up_strb = 1'b0; cyc(4);
        up_strb = 1'b1; hits = 0;
        for (int i = 0; i < 6; i++) begin cyc(1); if (illegal) hits++; end
        chk(hits == 1, "R8", "one pulse on rise with down low", hits, 1);
        chk(int'(count) == 1, "R8", "count held with down low", int'(count), 1);
        dn_strb = 1'b1; cyc(4);

        // R11: reset mid-run.
        tag = "R11";
        pulse_up();
        rst_n = 1'b0; cyc(2);
        chk(count == '0 && carry_n && borrow_n && !illegal, "R11",
            "reset mid-run", int'(count), 0);
        rst_n = 1'b1; cyc(3);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule